// File: doc/BRIEF.md
# UART Transmit Ring DMA Channel

This block is one memory-to-peripheral DMA channel that feeds a UART transmitter from a circular byte buffer in memory. Software sets up the ring through a 32-bit register port: base address, ring length and a free-space threshold. It then publishes bytes by moving a write pointer forward. The channel fetches one byte at a time over a request/response memory read port and offers each byte to the UART on a valid/ready byte stream. The read pointer moves forward only after the UART takes the byte.

Both pointers hold a 16-bit byte offset and a wrap flag above it. The difference between the two pointers, together with the two wrap flags, gives the number of bytes still to send and the room left for software. A level interrupt tells software when enough room has opened up. There are controls to run, drain, stop and warm-reset the channel. An optional 33rd address bit is available for buffers above 4 GiB.

Top module: `uart_txring_dma`

## Requirements
- R1: After reset the run, halt, drain, interrupt-enable and interrupt-flag bits read 0, both pointers read 0, the debug status reads 0, and irq, tx_valid and mem_req_valid are low.
- R2: A pointer is a byte offset in bits 15:0 with a wrap flag in bit 16. Pointer registers read back as written. When the read pointer's offset would reach the ring length, the offset returns to 0 and the wrap flag inverts.
- R3: Fill (offset 0x3C) equals write offset minus read offset, plus the ring length (offset 0x24) when the two wrap flags differ. Room (offset 0x40) equals length minus fill.
- R4: Each byte is read from address {X, base + read offset}. Base is at 0x1C. X is bit 0 of the address-extension enable (0x54) ANDed with bit 0 of the upper-base register (0x20). Bytes reach tx_data in ring order. The read pointer (0x30) advances once per accepted byte, and only one memory request is outstanding at a time.
- R5: The channel fetches only when fill is nonzero and either the run bit (0x08 bit 0) or the drain bit is set. With both clear, the read pointer does not move and no byte is sent.
- R6: While interrupt-enable (0x04 bit 0) is 1 and room is at least the threshold (0x28), the interrupt flag (0x00 bit 0) sets, irq goes high and interrupt-enable clears itself. Writing the flag register with bit 0 = 0 clears the flag.
- R7: Writing 1 to bit 0 of the drain register (0x14) makes the channel send all pending bytes even when the run bit is 0. The bit reads 1 until fill reaches 0 with no byte in flight, then clears itself.
- R8: While the halt bit (0x10 bit 0) is 1, no new fetch starts. The byte in flight is still delivered, and the run bit then clears. After halt returns to 0 the remaining bytes stay pending until run is set again.
- R9: Writing 1 to bit 0 of the warm-reset register (0x0C) clears the run bit and both pointers. Fill then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 33 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| tx_valid | output | 1 | Byte offered to the UART |
| tx_ready | input | 1 | UART accepts the byte |
| tx_data | output | 8 | Byte to the UART |
| irq | output | 1 | Level interrupt of this channel |

## Verification
The bench targets three places where an error would be visible:
- **Wrap arithmetic.** The write pointer is moved past the end of the ring so that the wrap flags differ. A design that ignored the flags would report a negative or tiny fill and stall, or send bytes twice.
- **Halt with a byte in flight.** The UART is stalled while a byte is held on the stream and halt is asserted. A wrong design would drop the held byte, send the following bytes anyway, or leave the run bit set.
- **Drain, interrupt and address extension.** Drain is used with run cleared and must clear itself. The interrupt is checked for staying quiet below the threshold and firing once above it. The extension bit is checked to change the fetched bytes only when both of its enabling bits are set.

// File: rtl/uart_txring_pkg.sv
package uart_txring_pkg;

    // register byte offsets; software decodes these
    localparam logic [7:0] REG_IRQ_FLAG = 8'h00;
    localparam logic [7:0] REG_IRQ_EN   = 8'h04;
    localparam logic [7:0] REG_RUN      = 8'h08;
    localparam logic [7:0] REG_WRST     = 8'h0C;
    localparam logic [7:0] REG_HALT     = 8'h10;
    localparam logic [7:0] REG_DRAIN    = 8'h14;
    localparam logic [7:0] REG_BASE     = 8'h1C;
    localparam logic [7:0] REG_BASE_HI  = 8'h20;
    localparam logic [7:0] REG_SIZE     = 8'h24;
    localparam logic [7:0] REG_LEVEL    = 8'h28;
    localparam logic [7:0] REG_WPTR     = 8'h2C;
    localparam logic [7:0] REG_RPTR     = 8'h30;
    localparam logic [7:0] REG_FILL     = 8'h3C;
    localparam logic [7:0] REG_ROOM     = 8'h40;
    localparam logic [7:0] REG_DBG      = 8'h50;
    localparam logic [7:0] REG_XADDR    = 8'h54;

    typedef enum logic [2:0] {
        MV_IDLE = 3'd0,
        MV_REQ  = 3'd1,
        MV_WAIT = 3'd2,
        MV_SEND = 3'd3,
        MV_DROP = 3'd4
    } mover_state_e;

    typedef struct packed {
        mover_state_e st;
        logic [7:0]   hold;
    } mover_t;

endpackage

// File: rtl/uart_txring_level.sv
module uart_txring_level #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W:0]   wr_ptr,
    input  logic [OFF_W:0]   rd_ptr,
    input  logic [OFF_W-1:0] ring_len,
    output logic [OFF_W:0]   fill,
    output logic [OFF_W:0]   room
);
    logic [OFF_W:0] span;

    always_comb begin
        span = {1'b0, wr_ptr[OFF_W-1:0]} - {1'b0, rd_ptr[OFF_W-1:0]};
        if (wr_ptr[OFF_W] != rd_ptr[OFF_W]) begin
            span = span + {1'b0, ring_len};
        end
        fill = span;
        room = {1'b0, ring_len} - span;
    end
endmodule

// File: rtl/uart_txring_mover.sv
module uart_txring_mover
    import uart_txring_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    output logic         mem_req_valid,
    input  logic         mem_req_ready,
    input  logic         mem_rsp_valid,
    input  logic [7:0]   mem_rsp_data,
    output logic         tx_valid,
    input  logic         tx_ready,
    output logic [7:0]   tx_data,
    output logic         busy,
    output logic         done,
    output mover_state_e state
);
    mover_t mv_d, mv_q;

    always_comb begin
        mv_d = mv_q;
        done = 1'b0;
        unique case (mv_q.st)
            MV_IDLE: if (start && !abort) mv_d.st = MV_REQ;
            MV_REQ: begin
                if (abort)              mv_d.st = MV_IDLE;
                else if (mem_req_ready) mv_d.st = MV_WAIT;
            end
            MV_WAIT: begin
                if (abort) begin
                    mv_d.st = mem_rsp_valid ? MV_IDLE : MV_DROP;
                end else if (mem_rsp_valid) begin
                    mv_d.st   = MV_SEND;
                    mv_d.hold = mem_rsp_data;
                end
            end
            MV_SEND: begin
                if (abort) begin
                    mv_d.st = MV_IDLE;
                end else if (tx_ready) begin
                    mv_d.st = MV_IDLE;
                    done    = 1'b1;
                end
            end
            MV_DROP: if (mem_rsp_valid) mv_d.st = MV_IDLE;
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv_q <= '{st: MV_IDLE, hold: 8'h00};
        end else begin
            mv_q <= mv_d;
        end
    end

    assign mem_req_valid = (mv_q.st == MV_REQ);
    assign tx_valid      = (mv_q.st == MV_SEND);
    assign tx_data       = mv_q.hold;
    assign busy          = (mv_q.st != MV_IDLE);
    assign state         = mv_q.st;
endmodule

// File: rtl/uart_txring_dma.sv
module uart_txring_dma
    import uart_txring_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int BASE_W = 32,
    parameter int REG_AW = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [BASE_W:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int PTR_W = OFF_W + 1;
    localparam int PAD_W = BASE_W - OFF_W;

    typedef struct packed {
        logic              run;
        logic              irq_en;
        logic              irq_flag;
        logic              halt;
        logic              drain;
        logic              xaddr;
        logic              base_hi;
        logic [BASE_W-1:0] base;
        logic [OFF_W-1:0]  size;
        logic [PTR_W-1:0]  level;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
    } regs_t;

    regs_t r_d, r_q;

    logic [PTR_W-1:0] fill, room;
    logic [PTR_W-1:0] rptr_next;
    logic [OFF_W-1:0] roff_inc;
    logic             mv_busy, mv_done, mv_start, wreset, fire;
    mover_state_e     mv_state;

    uart_txring_level #(.OFF_W(OFF_W)) u_level (
        .wr_ptr   (r_q.wptr),
        .rd_ptr   (r_q.rptr),
        .ring_len (r_q.size),
        .fill     (fill),
        .room     (room)
    );

    uart_txring_mover u_mover (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (mv_start),
        .abort         (wreset),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_data       (tx_data),
        .busy          (mv_busy),
        .done          (mv_done),
        .state         (mv_state)
    );

    assign wreset   = reg_we && (reg_addr == REG_WRST) && reg_wdata[0];
    assign mv_start = (r_q.run || r_q.drain) && !r_q.halt && (fill != '0) && !wreset;
    assign fire     = r_q.irq_en && (room >= r_q.level);

    // read pointer step with wrap-flag inversion at the ring end
    always_comb begin
        roff_inc = r_q.rptr[OFF_W-1:0] + 1'b1;
        if (roff_inc == r_q.size) begin
            rptr_next = {~r_q.rptr[OFF_W], {OFF_W{1'b0}}};
        end else begin
            rptr_next = {r_q.rptr[OFF_W], roff_inc};
        end
    end

    always_comb begin
        r_d = r_q;
        // hardware-side updates
        if (mv_done) r_d.rptr = rptr_next;
        if (fire) r_d.irq_flag = 1'b1;
        if (r_q.drain && !mv_busy && (fill == '0)) r_d.drain = 1'b0;
        if (r_q.halt && !mv_busy) begin
            r_d.run   = 1'b0;
            r_d.drain = 1'b0;
        end
        // software writes
        if (reg_we) begin
            case (reg_addr)
                REG_IRQ_FLAG: if (!reg_wdata[0]) r_d.irq_flag = fire;
                REG_IRQ_EN:   r_d.irq_en  = reg_wdata[0];
                REG_RUN:      r_d.run     = reg_wdata[0];
                REG_HALT:     r_d.halt    = reg_wdata[0];
                REG_DRAIN:    if (reg_wdata[0]) r_d.drain = 1'b1;
                REG_BASE:     r_d.base    = reg_wdata[BASE_W-1:0];
                REG_BASE_HI:  r_d.base_hi = reg_wdata[0];
                REG_SIZE:     r_d.size    = reg_wdata[OFF_W-1:0];
                REG_LEVEL:    r_d.level   = reg_wdata[PTR_W-1:0];
                REG_WPTR:     r_d.wptr    = reg_wdata[PTR_W-1:0];
                REG_RPTR:     r_d.rptr    = reg_wdata[PTR_W-1:0];
                REG_XADDR:    r_d.xaddr   = reg_wdata[0];
                default: ;
            endcase
        end
        // the firing condition always disarms the interrupt enable
        if (fire) r_d.irq_en = 1'b0;
        if (wreset) begin
            r_d.run   = 1'b0;
            r_d.drain = 1'b0;
            r_d.wptr  = '0;
            r_d.rptr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_IRQ_FLAG: reg_rdata[0]          = r_q.irq_flag;
            REG_IRQ_EN:   reg_rdata[0]          = r_q.irq_en;
            REG_RUN:      reg_rdata[0]          = r_q.run;
            REG_HALT:     reg_rdata[0]          = r_q.halt;
            REG_DRAIN:    reg_rdata[0]          = r_q.drain;
            REG_BASE:     reg_rdata[BASE_W-1:0] = r_q.base;
            REG_BASE_HI:  reg_rdata[0]          = r_q.base_hi;
            REG_SIZE:     reg_rdata[OFF_W-1:0]  = r_q.size;
            REG_LEVEL:    reg_rdata[PTR_W-1:0]  = r_q.level;
            REG_WPTR:     reg_rdata[PTR_W-1:0]  = r_q.wptr;
            REG_RPTR:     reg_rdata[PTR_W-1:0]  = r_q.rptr;
            REG_FILL:     reg_rdata[PTR_W-1:0]  = fill;
            REG_ROOM:     reg_rdata[PTR_W-1:0]  = room;
            REG_DBG:      reg_rdata[2:0]        = mv_state;
            REG_XADDR:    reg_rdata[0]          = r_q.xaddr;
            default: ;
        endcase
    end

    assign mem_req_addr = {r_q.xaddr & r_q.base_hi,
                           r_q.base + {{PAD_W{1'b0}}, r_q.rptr[OFF_W-1:0]}};
    assign irq = r_q.irq_flag;

    // plain views of state for the bound checker
    logic             cur_run, cur_irq_en, cur_drain, cur_halt;
    logic [PTR_W-1:0] cur_rptr;
    assign cur_run    = r_q.run;
    assign cur_irq_en = r_q.irq_en;
    assign cur_drain  = r_q.drain;
    assign cur_halt   = r_q.halt;
    assign cur_rptr   = r_q.rptr;
endmodule

// File: rtl/uart_txring_chk.sv
module uart_txring_chk #(
    parameter int OFF_W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_we,
    input logic         wreset,
    input logic         mem_req_valid,
    input logic         mem_req_ready,
    input logic         tx_valid,
    input logic         tx_ready,
    input logic [7:0]   tx_data,
    input logic         irq,
    input logic         cur_run,
    input logic         cur_irq_en,
    input logic         cur_drain,
    input logic         cur_halt,
    input logic [OFF_W:0] cur_rptr,
    input logic [OFF_W:0] fill
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !wreset) |=> mem_req_valid);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wreset) |=> (tx_valid && $stable(tx_data)));

    // R4
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !reg_we) |=> (cur_rptr != $past(cur_rptr)));

    // R5
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(cur_run || cur_drain));

    // R6
    irq_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !cur_irq_en);

    // R7
    drain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_drain) |-> ($past(fill == '0) || $past(wreset) || $past(cur_halt)));
endmodule

bind uart_txring_dma uart_txring_chk #(.OFF_W(OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .wreset        (wreset),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .irq           (irq),
    .cur_run       (cur_run),
    .cur_irq_en    (cur_irq_en),
    .cur_drain     (cur_drain),
    .cur_halt      (cur_halt),
    .cur_rptr      (cur_rptr),
    .fill          (fill)
);

// File: tb/uart_txring_dma_test.sv
`timescale 1ns/1ps
module uart_txring_dma_test;
    localparam logic [7:0] A_FLAG = 8'h00, A_IEN = 8'h04, A_RUN = 8'h08, A_RST = 8'h0C,
                           A_HALT = 8'h10, A_DRN = 8'h14, A_BASE = 8'h1C, A_BHI = 8'h20,
                           A_SIZE = 8'h24, A_LVL = 8'h28, A_WP = 8'h2C, A_RP = 8'h30,
                           A_FILL = 8'h3C, A_ROOM = 8'h40, A_DBG = 8'h50, A_XA = 8'h54;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0, reg_rdata;
    logic mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid;
    logic [32:0] mem_req_addr;
    logic [7:0] mem_rsp_data, tx_data;
    logic tx_valid, tx_ready = 1'b0, irq;

    always #2 clk = ~clk;

    uart_txring_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] expq[$];

    function automatic logic [7:0] mem_byte(input logic [32:0] a);
        return a[7:0] ^ a[15:8] ^ (a[32] ? 8'hC3 : 8'h00);
    endfunction

    // memory model: one cycle response latency, ready pattern
    int cyc = 0;
    logic pend = 1'b0;
    logic [32:0] paddr = '0;
    logic tx_hold = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 0;
        tx_ready <= tx_hold ? 1'b0 : ((cyc % 4) != 1);
        pend <= mem_req_valid && mem_req_ready;
        if (mem_req_valid && mem_req_ready) paddr <= mem_req_addr;
    end
    assign mem_rsp_valid = pend;
    assign mem_rsp_data  = mem_byte(paddr);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // monitor: scoreboard pop at each stream handshake
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
                check("R5 unexpected byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
            end else begin
                check("R4 stream byte", {24'h0, tx_data}, {24'h0, expq.pop_front()});
            end
        end
    end

    // bench model of the ring
    logic [31:0] m_base = 32'h0000_2340;
    logic m_bhi = 1'b1, m_x = 1'b0;
    logic [15:0] m_len = 16'd16;
    logic [16:0] m_wp = '0, m_rp = '0;

    function automatic logic [16:0] adv(input logic [16:0] p);
        logic [15:0] o;
        o = p[15:0] + 16'd1;
        if (o == m_len) return {~p[16], 16'h0};
        return {p[16], o};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chkreg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic push_next(input int k);
        for (int i = 0; i < k; i++) begin
            expq.push_back(mem_byte({m_x & m_bhi, m_base + {16'h0, m_rp[15:0]}}));
            m_rp = adv(m_rp);
        end
    endtask

    task automatic publish(input int n, input int k);
        for (int i = 0; i < n; i++) m_wp = adv(m_wp);
        push_next(k);
        wr(A_WP, {15'h0, m_wp});
    endtask

    task automatic drain_wait(input string tag);
        int t = 0;
        while (expq.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(tag, expq.size(), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chkreg("R1 run", A_RUN, 0);
        chkreg("R1 wptr", A_WP, 0);
        chkreg("R1 rptr", A_RP, 0);
        chkreg("R1 flag", A_FLAG, 0);
        chkreg("R1 debug", A_DBG, 0);
        check("R1 irq/tx/req", {29'h0, irq, tx_valid, mem_req_valid}, 0);

        wr(A_BASE, m_base);
        wr(A_BHI, 1);
        wr(A_SIZE, 16);
        wr(A_LVL, 4);
        chkreg("R3 room empty", A_ROOM, 16);
        chkreg("R3 fill empty", A_FILL, 0);

        // basic transfer, extension bit masked off (R4)
        wr(A_RUN, 1);
        publish(5, 5);
        drain_wait("R4 first burst");
        chkreg("R4 rptr after 5", A_RP, 32'h5);

        // wrap: fill with differing wrap flags
        wr(A_RUN, 0);
        publish(14, 0);
        chkreg("R2 wptr wrap", A_WP, 32'h10003);
        chkreg("R3 fill wrapped", A_FILL, 14);
        chkreg("R3 room wrapped", A_ROOM, 2);
        repeat (20) @(negedge clk);
        chkreg("R5 idle rptr", A_RP, 32'h5);
        wr(A_IEN, 1);
        repeat (5) @(negedge clk);
        check("R6 no irq below level", {31'h0, irq}, 0);
        chkreg("R6 ien held", A_IEN, 1);
        push_next(14);
        wr(A_RUN, 1);
        drain_wait("R2 wrap burst");
        chkreg("R2 rptr wrapped", A_RP, 32'h10003);
        check("R6 irq raised", {31'h0, irq}, 1);
        chkreg("R6 ien disarmed", A_IEN, 0);
        wr(A_FLAG, 0);
        repeat (3) @(negedge clk);
        check("R6 irq cleared", {31'h0, irq}, 0);

        // drain with run cleared
        wr(A_RUN, 0);
        publish(3, 3);
        wr(A_DRN, 1);
        chkreg("R7 drain busy", A_DRN, 1);
        begin
            int t = 0;
            logic [31:0] v = 1;
            while (v != 0 && t < 500) begin
                @(negedge clk); reg_addr = A_DRN; #1; v = reg_rdata; t++;
            end
            check("R7 drain self-clear", v, 0);
        end
        check("R7 drained all", expq.size(), 0);
        chkreg("R7 rptr", A_RP, 32'h10006);
        chkreg("R7 run untouched", A_RUN, 0);

        // halt with a byte in flight
        tx_hold = 1'b1;
        wr(A_RUN, 1);
        publish(4, 1);
        begin
            int t = 0;
            while (!tx_valid && t < 200) begin @(negedge clk); t++; end
        end
        wr(A_HALT, 1);
        tx_hold = 1'b0;
        repeat (20) @(negedge clk);
        chkreg("R8 run cleared", A_RUN, 0);
        chkreg("R8 one byte out", A_RP, 32'h10007);
        chkreg("R8 rest pending", A_FILL, 3);
        check("R8 in-flight delivered", expq.size(), 0);
        wr(A_HALT, 0);
        repeat (20) @(negedge clk);
        chkreg("R8 still pending", A_FILL, 3);
        push_next(3);
        wr(A_RUN, 1);
        drain_wait("R8 resume");
        chkreg("R8 rptr resumed", A_RP, 32'h1000A);

        // address extension bit
        m_x = 1'b1;
        wr(A_XA, 1);
        publish(2, 2);
        drain_wait("R4 extended address");

        // warm reset
        wr(A_RST, 1);
        chkreg("R9 run", A_RUN, 0);
        chkreg("R9 wptr", A_WP, 0);
        chkreg("R9 rptr", A_RP, 0);
        chkreg("R9 fill", A_FILL, 0);
        m_wp = '0; m_rp = '0;
        wr(A_RUN, 1);
        publish(2, 2);
        drain_wait("R9 restart from zero");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule